// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Wake-Up Filtering

This block is a full-duplex asynchronous serial port with a transmitter and a receiver that run independently and a baud generator that both share. A reload value divides the system clock into a sampling tick at sixteen times the bit rate. Both directions use one frame format, set by configuration inputs. A frame carries 7, 8 or 9 data bits, sent least significant bit first. An optional extra bit follows the data and acts as an even parity bit, an odd parity bit or a wake-up marker. The frame ends with one or two stop bits. The line idles high.

Software starts a transfer with a one-cycle write strobe. A single-entry receive buffer holds the last accepted frame until a read strobe frees it. Pulses on separate outputs request interrupts when a frame has been sent, when a frame has been received and when an error is found. In wake-up mode, only frames whose extra bit is 1 reach the buffer, which lets several receivers share one line and ignore traffic addressed to others. Parity, framing and overrun errors are held in sticky flags until software clears them.

Top module: `async_port`

## Requirements
- R1: Each bit on `txd` lasts 16*(`cfg_reload`+1) clock cycles. The first bit may be shorter by up to `cfg_reload` cycles because of the tick phase, so a whole frame of T bits keeps `tx_busy` high for between T*16*(`cfg_reload`+1)-`cfg_reload` and T*16*(`cfg_reload`+1) cycles.
- R2: A transmitted frame is a low start bit, then the data bits least significant first, then the extra bit if one is enabled, then the stop bits, which are high. The line is high when idle. `cfg_len` selects the data length: 0 gives 7 bits, 1 gives 8 bits, and 2 or 3 gives 9 bits. Data bits above the selected length are not sent.
- R3: `cfg_extra` selects the extra bit: 0 for none, 1 for even parity, 2 for odd parity, 3 for wake-up. With even parity, the data bits plus the parity bit hold an even number of ones. With odd parity they hold an odd number. In wake-up mode the transmitter sends `tx_wake`.
- R4: `cfg_stop2`=0 sends one stop bit and `cfg_stop2`=1 sends two.
- R5: A complete received frame sets `rx_valid` and pulses `rx_irq` for one cycle. `rx_data` then holds the data bits, with the bits above the selected length at zero. An `rx_rd` pulse clears `rx_valid`.
- R6: When parity is enabled and the received extra bit does not match the data, `err_par` is set. The data is still delivered.
- R7: When any stop bit is sampled low, `err_frm` is set.
- R8: When a frame completes while `rx_valid` is still set, the buffered data is kept unchanged and `err_ovr` is set.
- R9: In wake-up mode, a frame whose extra bit is 0 changes no output and no flag. A frame whose extra bit is 1 is received normally.
- R10: Error flags stay set until an `err_clr` pulse clears them. Each frame that finds an error pulses `err_irq` once.
- R11: A `tx_wr` pulse while `tx_busy` is high is ignored. `tx_irq` pulses once at the end of each frame, in the cycle that `tx_busy` falls.
- R12: The receiver checks the start bit at its middle. A low pulse shorter than half a bit starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_reload | input | 16 | Divider for the 16x sampling tick (tick period is value+1 cycles) |
| cfg_len | input | 2 | Data length select |
| cfg_extra | input | 2 | Extra bit select: none, even, odd, wake-up |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| tx_wr | input | 1 | Start a transmission of tx_data |
| tx_data | input | 9 | Transmit data |
| tx_wake | input | 1 | Wake-up bit value sent in wake-up mode |
| tx_busy | output | 1 | Transmitter is sending a frame |
| tx_irq | output | 1 | One-cycle pulse at the end of a frame |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line, asynchronous |
| rx_rd | input | 1 | Read strobe that frees the receive buffer |
| rx_data | output | 9 | Received data |
| rx_valid | output | 1 | Receive buffer is full |
| rx_irq | output | 1 | One-cycle pulse when a frame is buffered |
| err_clr | input | 1 | Clears all error flags |
| err_par | output | 1 | Sticky parity error |
| err_frm | output | 1 | Sticky framing error |
| err_ovr | output | 1 | Sticky overrun error |
| err_irq | output | 1 | One-cycle pulse when a frame finds an error |

## Verification
The properties assume that the configuration inputs do not change while a frame is being sent or received, and that `rxd` holds each bit long enough for the middle sample to settle. The bench changes the configuration only while both directions are idle. It drives the receive line one bit at a time, each bit held for exactly one bit period, and only shortens a bit on purpose when it produces a glitch or a bad stop bit, which it releases well before the receiver could mistake it for a new start. Strobes are single-cycle pulses driven away from the clock edge.

// File: rtl/async_pkg.sv
package async_pkg;
    localparam int MAX_DATA  = 9;
    localparam int TX_BITS   = 1 + MAX_DATA + 1 + 2;
    localparam int RX_BITS   = MAX_DATA + 1 + 2;
    localparam int IDX_W     = $clog2(TX_BITS);
    localparam int OVS       = 16;
    localparam int OVS_W     = $clog2(OVS);

    typedef enum logic [1:0] {
        XB_NONE = 2'd0,
        XB_EVEN = 2'd1,
        XB_ODD  = 2'd2,
        XB_WAKE = 2'd3
    } xbit_e;

    typedef enum logic [1:0] {
        RM_IDLE  = 2'd0,
        RM_START = 2'd1,
        RM_BITS  = 2'd2
    } rx_mode_e;

    function automatic logic [IDX_W-1:0] data_bits(input logic [1:0] len);
        case (len)
            2'd0:    return IDX_W'(7);
            2'd1:    return IDX_W'(8);
            default: return IDX_W'(9);
        endcase
    endfunction
endpackage

// File: rtl/apt_baud.sv
module apt_baud #(
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] reload,
    output logic          tick
);
    logic [RW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == '0);

    always_comb begin
        cnt_d = tick ? reload : cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/apt_tx.sv
module apt_tx
    import async_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wr,
    input  logic [MAX_DATA-1:0] data,
    input  logic                wake,
    input  logic [1:0]          len,
    input  xbit_e               extra,
    input  logic                stop2,
    output logic                busy,
    output logic                irq,
    output logic                txd
);
    typedef struct packed {
        logic               busy;
        logic               irq;
        logic [TX_BITS-1:0] bits;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   last;
        logic [OVS_W-1:0]   sub;
    } tx_st_t;

    tx_st_t d, q;

    always_comb begin
        logic [IDX_W-1:0]    n;
        logic [IDX_W-1:0]    pos;
        logic [MAX_DATA-1:0] dm;
        logic                xb;
        d     = q;
        d.irq = 1'b0;
        n     = data_bits(len);
        dm    = '0;
        for (int i = 0; i < MAX_DATA; i++)
            if (i < int'(n)) dm[i] = data[i];
        case (extra)
            XB_EVEN: xb = ^dm;
            XB_ODD:  xb = ~(^dm);
            default: xb = wake;
        endcase
        pos = n + IDX_W'(1);
        if (!q.busy) begin
            if (wr) begin
                d.bits    = '1;
                d.bits[0] = 1'b0;
                for (int i = 0; i < MAX_DATA; i++)
                    if (i < int'(n)) d.bits[i+1] = dm[i];
                if (extra != XB_NONE) begin
                    d.bits[pos] = xb;
                    pos         = pos + IDX_W'(1);
                end
                d.last = pos + IDX_W'(stop2);
                d.busy = 1'b1;
                d.idx  = '0;
                d.sub  = '0;
            end
        end else if (tick) begin
            if (q.sub == OVS_W'(OVS-1)) begin
                d.sub = '0;
                if (q.idx == q.last) begin
                    d.busy = 1'b0;
                    d.irq  = 1'b1;
                end else begin
                    d.idx = q.idx + IDX_W'(1);
                end
            end else begin
                d.sub = q.sub + OVS_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign irq  = q.irq;
    assign txd  = q.busy ? q.bits[q.idx] : 1'b1;
endmodule

// File: rtl/apt_rx.sv
module apt_rx
    import async_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                rxd,
    input  logic [1:0]          len,
    input  xbit_e               extra,
    input  logic                stop2,
    input  logic                rd,
    input  logic                clr,
    output logic [MAX_DATA-1:0] data,
    output logic                valid,
    output logic                irq,
    output logic                par,
    output logic                frm,
    output logic                ovr,
    output logic                eirq
);
    typedef struct packed {
        logic [1:0]          sync;
        rx_mode_e            mode;
        logic [OVS_W-1:0]    sub;
        logic [IDX_W-1:0]    idx;
        logic [RX_BITS-1:0]  bits;
        logic [MAX_DATA-1:0] buf_data;
        logic                valid;
        logic                irq;
        logic                par;
        logic                frm;
        logic                ovr;
        logic                eirq;
    } rx_st_t;

    rx_st_t d, q;

    always_comb begin
        logic                rxs;
        logic [IDX_W-1:0]    n;
        logic                hx;
        logic [IDX_W-1:0]    nb;
        logic [RX_BITS-1:0]  rb;
        logic [MAX_DATA-1:0] dm;
        logic                xb;
        logic                pe;
        logic                fe;
        logic                full;
        d      = q;
        d.irq  = 1'b0;
        d.eirq = 1'b0;
        d.sync = {q.sync[0], rxd};
        rxs    = q.sync[1];
        if (rd)  d.valid = 1'b0;
        if (clr) begin
            d.par = 1'b0;
            d.frm = 1'b0;
            d.ovr = 1'b0;
        end
        n  = data_bits(len);
        hx = (extra != XB_NONE);
        nb = n + IDX_W'(hx) + IDX_W'(1) + IDX_W'(stop2);
        rb = q.bits;
        rb[q.idx] = rxs;
        dm = '0;
        for (int i = 0; i < MAX_DATA; i++)
            if (i < int'(n)) dm[i] = rb[i];
        xb = rb[n];
        fe = 1'b0;
        for (int i = 0; i < RX_BITS; i++)
            if (i >= int'(n) + int'(hx) && i < int'(nb) && !rb[i]) fe = 1'b1;
        case (extra)
            XB_EVEN: pe = (^dm) ^ xb;
            XB_ODD:  pe = ~((^dm) ^ xb);
            default: pe = 1'b0;
        endcase
        full = d.valid;
        case (q.mode)
            RM_IDLE: begin
                if (tick && !rxs) begin
                    d.mode = RM_START;
                    d.sub  = '0;
                end
            end
            RM_START: begin
                if (tick) begin
                    if (q.sub == OVS_W'(OVS/2 - 1)) begin
                        d.mode = rxs ? RM_IDLE : RM_BITS;
                        d.sub  = '0;
                        d.idx  = '0;
                    end else begin
                        d.sub = q.sub + OVS_W'(1);
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (q.sub == OVS_W'(OVS-1)) begin
                        d.sub  = '0;
                        d.bits = rb;
                        if (q.idx == nb - IDX_W'(1)) begin
                            d.mode = RM_IDLE;
                            if (!(extra == XB_WAKE && !xb)) begin
                                if (pe) d.par = 1'b1;
                                if (fe) d.frm = 1'b1;
                                if (full) begin
                                    d.ovr = 1'b1;
                                end else begin
                                    d.buf_data = dm;
                                    d.valid    = 1'b1;
                                    d.irq      = 1'b1;
                                end
                                d.eirq = pe | fe | full;
                            end
                        end else begin
                            d.idx = q.idx + IDX_W'(1);
                        end
                    end else begin
                        d.sub = q.sub + OVS_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= '1;
        end else begin
            q <= d;
        end
    end

    assign data  = q.buf_data;
    assign valid = q.valid;
    assign irq   = q.irq;
    assign par   = q.par;
    assign frm   = q.frm;
    assign ovr   = q.ovr;
    assign eirq  = q.eirq;
endmodule

// File: rtl/async_port.sv
module async_port
    import async_pkg::*;
#(
    parameter int RELOAD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RELOAD_W-1:0] cfg_reload,
    input  logic [1:0]          cfg_len,
    input  logic [1:0]          cfg_extra,
    input  logic                cfg_stop2,
    input  logic                tx_wr,
    input  logic [MAX_DATA-1:0] tx_data,
    input  logic                tx_wake,
    output logic                tx_busy,
    output logic                tx_irq,
    output logic                txd,
    input  logic                rxd,
    input  logic                rx_rd,
    output logic [MAX_DATA-1:0] rx_data,
    output logic                rx_valid,
    output logic                rx_irq,
    input  logic                err_clr,
    output logic                err_par,
    output logic                err_frm,
    output logic                err_ovr,
    output logic                err_irq
);
    logic  tick;
    xbit_e xmode;

    assign xmode = xbit_e'(cfg_extra);

    apt_baud #(.RW(RELOAD_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (cfg_reload),
        .tick   (tick)
    );

    apt_tx u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr    (tx_wr),
        .data  (tx_data),
        .wake  (tx_wake),
        .len   (cfg_len),
        .extra (xmode),
        .stop2 (cfg_stop2),
        .busy  (tx_busy),
        .irq   (tx_irq),
        .txd   (txd)
    );

    apt_rx u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .rxd   (rxd),
        .len   (cfg_len),
        .extra (xmode),
        .stop2 (cfg_stop2),
        .rd    (rx_rd),
        .clr   (err_clr),
        .data  (rx_data),
        .valid (rx_valid),
        .irq   (rx_irq),
        .par   (err_par),
        .frm   (err_frm),
        .ovr   (err_ovr),
        .eirq  (err_irq)
    );
endmodule

// File: rtl/async_port_checks.sv
module async_port_checks #(
    parameter int DW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_busy,
    input logic          tx_irq,
    input logic          rx_rd,
    input logic [DW-1:0] rx_data,
    input logic          rx_valid,
    input logic          rx_irq,
    input logic          err_clr,
    input logic          err_par,
    input logic          err_frm,
    input logic          err_ovr
);
    a_r11_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (!tx_busy && $past(tx_busy)));

    a_r5_irq_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_valid && (!$past(rx_valid) || $past(rx_rd))));

    a_r5_read_frees: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd |=> (!rx_valid || rx_irq));

    a_r8_ovr_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_ovr) |-> ($stable(rx_data) && rx_valid));

    a_r10_par_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_par && !err_clr) |=> err_par);

    a_r10_frm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frm && !err_clr) |=> err_frm);

    a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ovr && !err_clr) |=> err_ovr);
endmodule

bind async_port async_port_checks #(.DW(async_pkg::MAX_DATA)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_busy  (tx_busy),
    .tx_irq   (tx_irq),
    .rx_rd    (rx_rd),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_irq   (rx_irq),
    .err_clr  (err_clr),
    .err_par  (err_par),
    .err_frm  (err_frm),
    .err_ovr  (err_ovr)
);

// File: tb/tb_async_port.sv
`timescale 1ns/1ps
module tb_async_port;
    localparam int RELOAD = 1;
    localparam int P      = RELOAD + 1;
    localparam int BIT    = 16 * P;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_reload = 16'(RELOAD);
    logic [1:0]  cfg_len = 2'd1;
    logic [1:0]  cfg_extra = 2'd0;
    logic        cfg_stop2 = 1'b0;
    logic        tx_wr = 1'b0;
    logic [8:0]  tx_data = '0;
    logic        tx_wake = 1'b0;
    logic        tx_busy, tx_irq, txd;
    logic        rxd;
    logic        rx_rd = 1'b0;
    logic [8:0]  rx_data;
    logic        rx_valid, rx_irq;
    logic        err_clr = 1'b0;
    logic        err_par, err_frm, err_ovr, err_irq;
    logic        use_loop = 1'b1;
    logic        line = 1'b1;

    int n_chk = 0, n_fail = 0;
    int n_rx = 0, n_err = 0, n_txirq = 0;
    int run = 0, last_len = 0;

    assign rxd = use_loop ? txd : line;

    always #4 clk = ~clk;

    async_port dut (
        .clk(clk), .rst_n(rst_n), .cfg_reload(cfg_reload), .cfg_len(cfg_len),
        .cfg_extra(cfg_extra), .cfg_stop2(cfg_stop2), .tx_wr(tx_wr),
        .tx_data(tx_data), .tx_wake(tx_wake), .tx_busy(tx_busy),
        .tx_irq(tx_irq), .txd(txd), .rxd(rxd), .rx_rd(rx_rd),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_irq(rx_irq),
        .err_clr(err_clr), .err_par(err_par), .err_frm(err_frm),
        .err_ovr(err_ovr), .err_irq(err_irq)
    );

    // Event counters sampled between edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_irq)  n_rx++;
            if (err_irq) n_err++;
            if (tx_irq)  n_txirq++;
            if (tx_busy) run++;
            else if (run != 0) begin
                last_len = run;
                run = 0;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    function automatic int len_of(input logic [1:0] l);
        return (l == 2'd0) ? 7 : (l == 2'd1) ? 8 : 9;
    endfunction

    task automatic pulse_rd();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    // Loopback frame: probe the line, time the frame, check the receiver.
    task automatic tx_probe(input logic [8:0] d, input logic wk, input bit poke, input string tag);
        int n, tot, pos, rx0, tx0;
        logic [15:0] exp, got, msk;
        logic [8:0] dm;
        n = len_of(cfg_len);
        dm = '0;
        for (int i = 0; i < n; i++) dm[i] = d[i];
        exp = '1; exp[0] = 1'b0;
        for (int i = 0; i < n; i++) exp[1+i] = dm[i];
        pos = 1 + n;
        if (cfg_extra != 2'd0) begin
            exp[pos] = (cfg_extra == 2'd1) ? ^dm : (cfg_extra == 2'd2) ? ~(^dm) : wk;
            pos++;
        end
        tot = pos + 1 + int'(cfg_stop2);
        msk = '0;
        for (int i = 0; i < tot; i++) msk[i] = 1'b1;
        rx0 = n_rx; tx0 = n_txirq;
        @(negedge clk); tx_data = d; tx_wake = wk; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
        got = '1;
        for (int b = 0; b < tot; b++) begin
            repeat ((b == 0) ? BIT/2 : BIT) @(negedge clk);
            got[b] = txd;
            if (poke && b == 3) begin
                tx_data = ~d; tx_wr = 1'b1;
                @(negedge clk); tx_wr = 1'b0;
            end
        end
        while (tx_busy) @(negedge clk);
        @(negedge clk);
        check((got & msk) == (exp & msk), {tag, " frame bits"}, int'(got & msk), int'(exp & msk));
        check(last_len >= tot*BIT - RELOAD && last_len <= tot*BIT, "R1 frame duration", last_len, tot*BIT);
        check(n_txirq == tx0 + 1, "R11 one tx_irq per frame", n_txirq - tx0, 1);
        check(rx_valid == 1'b1 && rx_data == dm, {tag, " R5 loopback data"}, int'(rx_data), int'(dm));
        check(n_rx == rx0 + 1, "R5 one rx_irq", n_rx - rx0, 1);
        pulse_rd();
        @(negedge clk);
        check(rx_valid == 1'b0, "R5 read clears valid", int'(rx_valid), 0);
    endtask

    // Bench-driven frame on the receive line
    task automatic line_send(input logic [8:0] d, input int n, input bit hx, input logic xb,
                             input bit bad_stop);
        @(negedge clk); line = 1'b0;
        repeat (BIT - 1) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            line = d[i];
            repeat (BIT) @(negedge clk);
        end
        if (hx) begin
            line = xb;
            repeat (BIT) @(negedge clk);
        end
        if (bad_stop) begin
            line = 1'b0;
            repeat (24) @(negedge clk);
            line = 1'b1;
            repeat (BIT - 24) @(negedge clk);
        end else begin
            line = 1'b1;
            repeat (BIT) @(negedge clk);
        end
        repeat (BIT) @(negedge clk);
    endtask

    initial begin
        int rx0, e0;
        repeat (3) @(negedge clk);
        check(txd == 1'b1 && tx_busy == 1'b0, "R2 reset idle high", int'(txd), 1);
        check(rx_valid == 1'b0 && rx_irq == 1'b0, "R5 reset buffer empty", int'(rx_valid), 0);
        check({err_par, err_frm, err_ovr} == 3'b000, "R10 reset flags clear", int'({err_par, err_frm, err_ovr}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // 8 data bits, no extra, one stop
        tx_probe(9'h0A5, 1'b0, 1'b0, "R2");
        // 7 data bits, even parity: upper bits dropped
        cfg_len = 2'd0; cfg_extra = 2'd1;
        tx_probe(9'h1FF, 1'b0, 1'b0, "R3 even");
        tx_probe(9'h012, 1'b0, 1'b0, "R3 even2");
        // 9 data bits, odd parity, two stops
        cfg_len = 2'd2; cfg_extra = 2'd2; cfg_stop2 = 1'b1;
        tx_probe(9'h155, 1'b0, 1'b0, "R4 odd two-stop");
        // write during busy ignored
        cfg_len = 2'd1; cfg_extra = 2'd0; cfg_stop2 = 1'b0;
        tx_probe(9'h03C, 1'b0, 1'b1, "R11 busy write");
        // wake-up bit driven by tx_wake
        cfg_extra = 2'd3;
        tx_probe(9'h0C3, 1'b1, 1'b0, "R3 wake tx");

        use_loop = 1'b0;
        repeat (BIT) @(negedge clk);

        // R6 parity error: 8 bits even parity, data 0x0F needs 0, send 1
        cfg_extra = 2'd1;
        e0 = n_err;
        line_send(9'h00F, 8, 1'b1, 1'b1, 1'b0);
        check(err_par == 1'b1, "R6 parity flag", int'(err_par), 1);
        check(rx_valid && rx_data == 9'h00F, "R6 data delivered", int'(rx_data), 'h0F);
        check(n_err == e0 + 1, "R10 err_irq pulse", n_err - e0, 1);
        pulse_rd();
        // good frame keeps sticky flag
        line_send(9'h00F, 8, 1'b1, 1'b0, 1'b0);
        check(err_par == 1'b1 && err_frm == 1'b0, "R10 parity sticky", int'(err_par), 1);
        pulse_rd();
        pulse_clr();
        @(negedge clk);
        check(err_par == 1'b0, "R10 clear", int'(err_par), 0);

        // R7 framing error
        cfg_extra = 2'd0;
        line_send(9'h081, 8, 1'b0, 1'b0, 1'b1);
        check(err_frm == 1'b1 && err_par == 1'b0, "R7 framing flag", int'(err_frm), 1);
        check(rx_data == 9'h081, "R7 data", int'(rx_data), 'h81);
        pulse_rd();
        pulse_clr();

        // R8 overrun
        rx0 = n_rx;
        line_send(9'h011, 8, 1'b0, 1'b0, 1'b0);
        line_send(9'h022, 8, 1'b0, 1'b0, 1'b0);
        check(rx_valid && rx_data == 9'h011, "R8 older data kept", int'(rx_data), 'h11);
        check(err_ovr == 1'b1, "R8 overrun flag", int'(err_ovr), 1);
        check(n_rx == rx0 + 1, "R8 single rx_irq", n_rx - rx0, 1);
        pulse_rd();
        pulse_clr();
        @(negedge clk);
        check({err_par, err_frm, err_ovr} == 3'b000, "R10 all cleared", int'({err_par, err_frm, err_ovr}), 0);

        // R9 wake-up filtering
        cfg_extra = 2'd3;
        rx0 = n_rx; e0 = n_err;
        line_send(9'h044, 8, 1'b1, 1'b0, 1'b0);
        check(rx_valid == 1'b0 && n_rx == rx0, "R9 unmarked frame dropped", n_rx - rx0, 0);
        check(n_err == e0 && err_ovr == 1'b0, "R9 no flags", n_err - e0, 0);
        line_send(9'h045, 8, 1'b1, 1'b1, 1'b0);
        check(rx_valid && rx_data == 9'h045, "R9 marked frame accepted", int'(rx_data), 'h45);
        pulse_rd();

        // R12 short glitch starts no frame
        cfg_extra = 2'd0;
        rx0 = n_rx; e0 = n_err;
        @(negedge clk); line = 1'b0;
        repeat (4) @(negedge clk);
        line = 1'b1;
        repeat (3 * BIT) @(negedge clk);
        check(rx_valid == 1'b0 && n_rx == rx0 && n_err == e0, "R12 glitch ignored", n_rx - rx0, 0);
        line_send(9'h05A, 8, 1'b0, 1'b0, 1'b0);
        check(rx_valid && rx_data == 9'h05A, "R12 frame after glitch", int'(rx_data), 'h5A);

        finish_run();
    end
endmodule